// File: doc/BRIEF.md
# Serial Peripheral Port with Low-Power Halt Handling

This block is a byte-wide serial peripheral port that runs either as the clock-driving master or as a slave clocked from outside. A single-bit register bus reaches a control/status word and a data word. Writing the data word loads the transmit shifter. In master mode the write also starts a transfer, timed by an internal divider. A completion flag and a write-collision flag sit in the status word, and each is cleared by writing a one to its bit position.

The block watches a level input, `stop_mode`, that marks the chip's low-power halt. While it is high, the master clock divider is frozen: a master transfer in progress holds its bit position and serial clock level, and it resumes from there once the level drops. A slave keeps shifting on the external clock during the halt. A byte that finishes in that time is recorded but not flagged, and the flag appears once the halt ends. A falling `stop_mode` is taken as an interrupt wake-up. Leaving the halt through `rst` clears everything and disables the port.

Top module: `spi_stop_ctrl`

## Requirements
- R1: A cycle with `rst` high clears the control word (enable, master, divider), both flags and `reg_rdata`, and drives `sclk_o` low. After that, data writes are ignored until the enable bit is written again.
- R2: When master (ctrl bit 1) and enabled (ctrl bit 0), a data write (`reg_addr`=1) while idle starts an 8-bit transfer, most significant bit first. `sclk_o` idles low and toggles every `div+1` clocks, where div is ctrl bits 5:2. `sdi_i` is sampled on each rising `sclk_o`, and `sdo_o` moves to the next bit after each falling one.
- R3: The completion flag (status bit 6) is set when a byte completes outside the halt. Writing the control word with bit 6 set clears it.
- R4: While `stop_mode` is high, a master's `sclk_o` and bit position are frozen. After `stop_mode` falls, the transfer continues and delivers the same bytes in both directions.
- R5: Outside the halt, a data write during a transfer sets the collision flag (status bit 7) and leaves the byte being shifted unchanged. Writing the control word with bit 7 set clears the flag.
- R6: When enabled as slave (ctrl bit 1 = 0), the block shifts on the synchronised `sclk_i` while `ss_n_i` is low. It takes `sdi_i` on rising edges, presents its loaded byte on `sdo_o` most significant bit first, and after 8 bits makes the byte readable at data address 1.
- R7: A slave byte that completes while `stop_mode` is high does not set the completion flag. The flag is set at the first clock edge that samples `stop_mode` low, so it shows in `reg_rdata` one cycle later.
- R8: While `stop_mode` is high, a data write during a slave transfer sets no collision flag and overwrites the shift register at once.
- R9: `reg_rdata` is registered and shows, one cycle after `reg_addr` is presented, either the status word {collision, completion, div, master, enable} (address 0) or the last received byte (address 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | Low-power halt level; a falling edge is an interrupt wake-up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sdo_o | output | 1 | Serial data out (master out or slave out) |
| sclk_i | input | 1 | External serial clock in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in (master in or slave in) |

## Verification
The hardest case to reach is a slave byte that starts and finishes inside the halt and also has a data write landing midway through it. The bench raises `stop_mode` before selecting the slave and clocks four bits. It then writes the data word in the gap after the fourth falling edge, once the synchroniser has shifted, and clocks the last four bits. This shows the overwritten shifter in both the returned bits and the received byte. Dropping `stop_mode` with the status address already presented lets the bench see the exact cycle the deferred flag appears. A per-clock reference of the master serial clock, which advances only on clocks where the halt is low, checks the frozen-and-resumed transfer.

// File: rtl/spi_stop_pkg.sv
package spi_stop_pkg;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned MST_BIT = 1;
  localparam int unsigned DIV_LSB = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  function automatic int unsigned done_bit_pos(int unsigned div_w);
    return DIV_LSB + div_w;
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_div);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic ss_n_i,
  output logic s_rise,
  output logic s_fall,
  output logic s_active
);
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] ss_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      ss_p  <= '1;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sclk_i};
      ss_p  <= {ss_p[STAGES-2:0], ss_n_i};
    end
  end

  assign s_rise   = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign s_fall   = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign s_active = ~ss_p[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  logic              s_rise,
  input  logic              s_fall,
  input  logic              s_active,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              m_busy,
  output logic              done_p,
  output logic [DATA_W-1:0] rx_data
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned LAST  = DATA_W - 1;

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              smp, sclk_q, busy_q;
  logic              rise_ev, fall_ev;

  always_comb begin
    if (mst) begin
      rise_ev = tick && busy_q && !sclk_q;
      fall_ev = tick && busy_q && sclk_q;
    end else begin
      rise_ev = s_rise && s_active;
      fall_ev = s_fall && s_active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      smp     <= 1'b0;
      sclk_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_p  <= 1'b0;
      rx_data <= '0;
    end else begin
      done_p <= 1'b0;
      if (!en) begin
        busy_q  <= 1'b0;
        sclk_q  <= 1'b0;
        bit_cnt <= '0;
      end else begin
        if (rise_ev) begin
          smp <= sdi_i;
          if (mst) sclk_q <= 1'b1;
        end
        if (fall_ev) begin
          shreg   <= {shreg[DATA_W-2:0], smp};
          bit_cnt <= bit_cnt + 1'b1;
          if (mst) sclk_q <= 1'b0;
          if (bit_cnt == CNT_W'(LAST)) begin
            bit_cnt <= '0;
            done_p  <= 1'b1;
            rx_data <= {shreg[DATA_W-2:0], smp};
            if (mst) busy_q <= 1'b0;
          end
        end
        if (!mst && !s_active) bit_cnt <= '0;
        if (load) begin
          shreg <= load_data;
          if (mst && !busy_q) begin
            busy_q  <= 1'b1;
            bit_cnt <= '0;
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = shreg[DATA_W-1];
  assign m_busy = busy_q;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic done_p,
  input  logic wcol_set,
  input  logic clr_done,
  input  logic clr_wcol,
  output logic done_flag,
  output logic wcol_flag
);
  logic stop_q, pend;
  logic wake;

  assign wake = stop_q & ~stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q    <= 1'b0;
      pend      <= 1'b0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
    end else begin
      stop_q <= stop;
      if (clr_done) done_flag <= 1'b0;
      if (clr_wcol) wcol_flag <= 1'b0;
      if (done_p) begin
        if (stop) pend <= 1'b1;
        else      done_flag <= 1'b1;
      end
      if (wake && pend) begin
        done_flag <= 1'b1;
        pend      <= 1'b0;
      end
      if (wcol_set) wcol_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_stop_ctrl.sv
module spi_stop_ctrl
  import spi_stop_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_mode,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              sdi_i
);
  localparam int unsigned DONE_BIT = done_bit_pos(DIV_W);
  localparam int unsigned WCOL_BIT = DONE_BIT + 1;

  logic             en_q, mst_q;
  logic [DIV_W-1:0] div_q;
  logic             wr_ctrl, wr_data, busy, collide, load;
  logic             tick, s_rise, s_fall, s_active;
  logic             m_busy, done_p, done_flag, wcol_flag;
  logic [DATA_W-1:0] rx_data, rd_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign busy    = mst_q ? m_busy : s_active;
  assign collide = wr_data && en_q && busy && !stop_mode;
  assign load    = wr_data && en_q && !collide;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      mst_q <= 1'b0;
      div_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= reg_wdata[EN_BIT];
      mst_q <= reg_wdata[MST_BIT];
      div_q <= reg_wdata[DIV_LSB +: DIV_W];
    end
  end

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst),
    .clr(!m_busy || !en_q),
    .run(en_q && mst_q && m_busy && !stop_mode),
    .half_div(div_q), .tick(tick)
  );

  spi_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
    .s_rise(s_rise), .s_fall(s_fall), .s_active(s_active)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .en(en_q), .mst(mst_q),
    .load(load), .load_data(reg_wdata), .tick(tick),
    .s_rise(s_rise), .s_fall(s_fall), .s_active(s_active),
    .sdi_i(sdi_i), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .m_busy(m_busy), .done_p(done_p), .rx_data(rx_data)
  );

  spi_flag_unit u_flags (
    .clk(clk), .rst(rst), .stop(stop_mode), .done_p(done_p),
    .wcol_set(collide),
    .clr_done(wr_ctrl && reg_wdata[DONE_BIT]),
    .clr_wcol(wr_ctrl && reg_wdata[WCOL_BIT]),
    .done_flag(done_flag), .wcol_flag(wcol_flag)
  );

  always_comb begin
    rd_ctrl                     = '0;
    rd_ctrl[EN_BIT]             = en_q;
    rd_ctrl[MST_BIT]            = mst_q;
    rd_ctrl[DIV_LSB +: DIV_W]   = div_q;
    rd_ctrl[DONE_BIT]           = done_flag;
    rd_ctrl[WCOL_BIT]           = wcol_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (reg_addr == ADDR_DATA) ? rx_data : rd_ctrl;
  end
endmodule

// File: rtl/spi_stop_ctrl_chk.sv
module spi_stop_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic stop_mode,
  input logic reg_wr,
  input logic reg_addr,
  input logic en,
  input logic mst,
  input logic busy,
  input logic m_busy,
  input logic done_flag,
  input logic wcol_flag,
  input logic sclk_o,
  input logic any_rdata
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      // R1
      reset_state_chk: assert (!en && !mst && !done_flag && !wcol_flag && !sclk_o && !any_rdata)
        else $error("reset state not cleared");
    end
  end

  // R4
  sclk_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_mode && mst) |=> $stable(sclk_o));

  // R7
  no_done_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_mode |=> !$rose(done_flag));

  // R8
  no_wcol_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_mode |=> !$rose(wcol_flag));

  // R5
  wcol_on_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr && en && busy && !stop_mode) |=> wcol_flag);

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mst && !m_busy) |=> !sclk_o);
endmodule

bind spi_stop_ctrl spi_stop_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .stop_mode(stop_mode),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .en(en_q), .mst(mst_q), .busy(busy), .m_busy(m_busy),
  .done_flag(done_flag), .wcol_flag(wcol_flag),
  .sclk_o(sclk_o), .any_rdata(|reg_rdata)
);

// File: tb/spi_stop_ctrl_bench.sv
module spi_stop_ctrl_bench;
  localparam int HALF_S = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, stop_mode, reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sclk_o, sdo_o, sclk_i, ss_n_i, sdi_i;
  logic       slave_bit, miso_bit, drive_slave;

  assign sdi_i = drive_slave ? slave_bit : miso_bit;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  spi_stop_ctrl u_spi_stop_ctrl (
    .clk(clk), .rst(rst), .stop_mode(stop_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .sclk_i(sclk_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // bench-side peer of the master transfer
  logic [7:0] miso_byte = 8'h00;
  logic [7:0] mosi_got  = 8'h00;
  int         fall_idx  = 0;
  always @(negedge sclk_o) fall_idx++;
  assign miso_bit = (fall_idx >= 0 && fall_idx < 8) ? miso_byte[7 - fall_idx] : 1'b0;
  always @(posedge sclk_o) mosi_got = {mosi_got[6:0], sdo_o};

  // reference model of the master serial clock
  logic [5:0] b_ctrl = 6'h00;
  bit m_on = 0, m_sclk = 0, model_en = 0;
  int m_ph = 0, m_edges = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_on = 0; m_sclk = 0; m_ph = 0; m_edges = 0;
    end else if (reg_wr && reg_addr == 1'b0 && !reg_wdata[0]) begin
      m_on = 0; m_sclk = 0;
    end else if (!m_on) begin
      if (reg_wr && reg_addr == 1'b1 && b_ctrl[0] && b_ctrl[1]) begin
        m_on = 1; m_ph = 0; m_edges = 0;
      end
    end else if (!stop_mode) begin
      if (m_ph == int'(b_ctrl[5:2])) begin
        m_ph = 0;
        m_sclk = !m_sclk;
        m_edges++;
        if (m_edges == 16) m_on = 0;
      end else begin
        m_ph++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && model_en) chk("R2/R4 sclk per-cycle", sclk_o, m_sclk);
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic setc(input logic [7:0] v);
    b_ctrl = v[5:0];
    wr(1'b0, v);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_master();
    while (m_on) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o);
    @(negedge clk);
    slave_bit = b;
    repeat (HALF_S) @(negedge clk);
    o = sdo_o;
    sclk_i = 1'b1;
    repeat (HALF_S) @(negedge clk);
    sclk_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic [7:0] got;
    logic       ob;
    logic       s0;
    rst = 1; stop_mode = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    sclk_i = 0; ss_n_i = 1; slave_bit = 0; drive_slave = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(1'b0, r);
    chk("R1 status after reset", r, 8'h00);
    chk("R1 sclk_o after reset", sclk_o, 1'b0);

    // R2/R3 master transfer, div=1
    setc(8'h07);
    rd(1'b0, r);
    chk("R9 status layout", r, 8'h07);
    miso_byte = 8'h3C; fall_idx = 0; model_en = 1;
    wr(1'b1, 8'hA5);
    wait_master();
    rd(1'b0, r);
    chk("R3 done flag", r[6], 1'b1);
    chk("R5 no collision", r[7], 1'b0);
    rd(1'b1, r);
    chk("R2 master received", r, 8'h3C);
    chk("R2 master sent", mosi_got, 8'hA5);
    setc(8'h47);
    rd(1'b0, r);
    chk("R3 done cleared", r[6], 1'b0);

    // R4 master halted mid-byte, div=2
    setc(8'h0B);
    miso_byte = 8'hC9; fall_idx = 0;
    wr(1'b1, 8'h5A);
    repeat (20) @(negedge clk);
    stop_mode = 1;
    @(negedge clk);
    s0 = sclk_o;
    repeat (30) @(negedge clk);
    chk("R4 sclk frozen", sclk_o, s0);
    rd(1'b0, r);
    chk("R4 no done during halt", r[6], 1'b0);
    stop_mode = 0;
    wait_master();
    rd(1'b1, r);
    chk("R4 resumed received", r, 8'hC9);
    chk("R4 resumed sent", mosi_got, 8'h5A);
    rd(1'b0, r);
    chk("R4 done after resume", r[6], 1'b1);

    // R5 collision outside halt
    setc(8'hC7);
    miso_byte = 8'h81; fall_idx = 0;
    wr(1'b1, 8'h66);
    repeat (6) @(negedge clk);
    wr(1'b1, 8'hFF);
    rd(1'b0, r);
    chk("R5 collision flag", r[7], 1'b1);
    wait_master();
    chk("R5 shifter unchanged", mosi_got, 8'h66);
    rd(1'b1, r);
    chk("R5 received intact", r, 8'h81);
    setc(8'h87);
    rd(1'b0, r);
    chk("R5 collision cleared", r[7], 1'b0);
    chk("R3 done kept by other clear", r[6], 1'b1);
    model_en = 0;

    // R6 slave transfer
    setc(8'hC1);
    drive_slave = 1;
    wr(1'b1, 8'h96);
    @(negedge clk); ss_n_i = 0;
    repeat (HALF_S) @(negedge clk);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      sbit(8'h71 >> i, ob);
      got = {got[6:0], ob};
    end
    repeat (HALF_S) @(negedge clk);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    chk("R6 slave sent", got, 8'h96);
    rd(1'b1, r);
    chk("R6 slave received", r, 8'h71);
    rd(1'b0, r);
    chk("R6 slave done", r[6], 1'b1);

    // R7/R8 slave during halt with mid-byte write
    setc(8'h41);
    wr(1'b1, 8'hC3);
    stop_mode = 1;
    @(negedge clk); ss_n_i = 0;
    repeat (HALF_S) @(negedge clk);
    got = 8'h00;
    for (int i = 7; i >= 4; i--) begin
      sbit(8'h2E >> i, ob);
      got = {got[6:0], ob};
    end
    repeat (5) @(negedge clk);
    wr(1'b1, 8'hFF);
    for (int i = 3; i >= 0; i--) begin
      sbit(8'h2E >> i, ob);
      got = {got[6:0], ob};
    end
    repeat (HALF_S) @(negedge clk);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    chk("R8 halt write reached shifter", got, 8'hCF);
    rd(1'b1, r);
    chk("R8 received after overwrite", r, 8'hFE);
    rd(1'b0, r);
    chk("R8 no collision in halt", r[7], 1'b0);
    chk("R7 done held in halt", r[6], 1'b0);
    @(negedge clk);
    stop_mode = 0;
    @(negedge clk);
    chk("R7 flag not yet visible", reg_rdata[6], 1'b0);
    @(negedge clk);
    chk("R7 flag one cycle after wake", reg_rdata[6], 1'b1);
    drive_slave = 0;

    // R1 reset exit from halt mid-transfer
    setc(8'h07);
    model_en = 1; fall_idx = 0;
    wr(1'b1, 8'h33);
    repeat (10) @(negedge clk);
    stop_mode = 1;
    repeat (3) @(negedge clk);
    rst = 1; b_ctrl = 6'h00;
    repeat (2) @(negedge clk);
    rst = 0; stop_mode = 0;
    rd(1'b0, r);
    chk("R1 status after reset exit", r, 8'h00);
    chk("R1 sclk low after reset exit", sclk_o, 1'b0);
    wr(1'b1, 8'h12);
    repeat (10) @(negedge clk);
    chk("R1 disabled ignores data write", sclk_o, 1'b0);
    rd(1'b0, r);
    chk("R1 still disabled", r, 8'h00);
    model_en = 0;

    finish_run();
  end
endmodule